// File: doc/BRIEF.md
# USB Host Interrupt Status Register

This block keeps the four sticky interrupt-cause flags of a USB host controller, plus the enable mask that decides which of them reach the interrupt line. Other logic reports events to it as strobes and levels. The descriptor engine reports finished transactions, with qualifiers for error, short packet and interrupt-on-complete. The port logic presents each port's change bit, force-resume bit, suspend state and companion-ownership bit. The frame counter presents its bit 13. The block turns these into flag sets. Software reads the flags and clears them through a small word-addressed register port.

Each event detector is a two-state machine. EDGE_PRIME is entered on reset. The transition T_ARM leaves it after the first clock and only captures the input. In EDGE_TRACK the detector stays put (transition T_HOLD) and compares each sample with the one before. A toggle-mode detector watches the frame bit. A rise-mode detector watches each port's change bit and each port's force-resume bit. The flag bank merges hardware sets with software clears. If both hit one bit in the same cycle, the set is kept.

Two word addresses are decoded. Word 0 holds the status flags and word 1 holds the interrupt enables. Any other word reads zero and ignores writes.

Top module: `usbsts_top`

## Requirements
- R1: Status (word 0) bit layout: bit 0 transaction interrupt, bit 1 error interrupt, bit 2 port change, bit 3 frame rollover. Bits 31..4 of every read are zero. Status and enables are zero after reset, and words other than 0 and 1 read zero.
- R2: A write to word 0 with reg_be[0]=1 clears each flag whose data bit is 1. Data bits that are 0, or a write with reg_be[0]=0, leave the flags unchanged. Set flags stay set until cleared this way.
- R3: The rollover flag (bit 3) sets on the clock after frame_rollbit changes value, in either direction. A steady frame_rollbit never sets it. The first clock after reset only samples the input and never sets the flag.
- R4: The port change flag (bit 2) sets when, for any port p, port_chg[p] goes from 0 to 1 while port_owner[p]=0. A change bit that stays at 1 does not set the flag again. A port with owner 1 never sets it.
- R5: The port change flag also sets when port_resume[p] goes from 0 to 1 while port_owner[p]=0 and port_susp[p]=1. A force-resume rise on a port that is not suspended does nothing.
- R6: Bit 0 sets on the clock after txn_done=1 with txn_ioc=1 or txn_short=1. Nothing sets without txn_done.
- R7: Bit 1 sets on the clock after txn_done=1 with txn_err=1. If txn_ioc is also 1, bits 0 and 1 set on the same clock.
- R8: A hardware set and a software clear of the same bit in the same clock leave that bit set.
- R9: Word 1 bits 3..0 are read/write enables, written when reg_be[0]=1. irq is 1 exactly when some status bit and the enable bit in the same position are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_rollbit | input | 1 | Bit 13 of the frame counter |
| port_owner | input | NPORTS | Per-port companion ownership (1 = not ours) |
| port_chg | input | NPORTS | Per-port change bit level |
| port_resume | input | NPORTS | Per-port force-resume bit level |
| port_susp | input | NPORTS | Per-port suspended level |
| txn_done | input | 1 | Transaction completion strobe |
| txn_ioc | input | 1 | Completed descriptor requested interrupt-on-complete |
| txn_err | input | 1 | Completion ended in an error condition |
| txn_short | input | 1 | Completion received fewer bytes than expected |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_be | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench clears every subset of flags and checks that only those flags drop. A decoder that cleared on written zeros would drop the wrong bits, and one that ignored byte enables would clear with lane 0 disabled. It sweeps owner, suspend and edge kind for every port, so a missing ownership or suspend gate would show up as a spurious port-change flag. Frame-bit toggles are driven in both directions and after a reset with the bit held high. Detecting only rising toggles, or comparing against a reset value instead of a first sample, would give the wrong rollover flag. The bench also runs a clear and a set on the same bit in the same cycle, where a clear-wins design loses the event, and sweeps every status/enable pair against irq.

// File: rtl/usbsts_pkg.sv
package usbsts_pkg;

    localparam int STS_BITS = 4;
    localparam int REG_W    = 32;

    localparam int B_TXN  = 0;
    localparam int B_ERR  = 1;
    localparam int B_PORT = 2;
    localparam int B_ROLL = 3;

    typedef enum logic {
        EDGE_PRIME,
        EDGE_TRACK
    } edge_state_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_STATUS,
        ACC_ENABLE
    } reg_sel_e;

endpackage

// File: rtl/usbsts_edge_fsm.sv
module usbsts_edge_fsm
    import usbsts_pkg::*;
#(
    parameter bit TOGGLE_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic evt
);

    edge_state_e state_q, state_d;
    logic        prev_q;
    logic        edge_hit;

    generate
        if (TOGGLE_MODE) begin : g_toggle
            assign edge_hit = din ^ prev_q;
        end else begin : g_rise
            assign edge_hit = din & ~prev_q;
        end
    endgenerate

    // Next state: T_ARM (PRIME -> TRACK), T_HOLD (TRACK -> TRACK)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_PRIME: state_d = EDGE_TRACK;
            EDGE_TRACK: state_d = EDGE_TRACK;
            default:    state_d = EDGE_PRIME;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EDGE_PRIME;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            prev_q  <= din;
        end
    end

    always_comb begin
        evt = 1'b0;
        unique case (state_q)
            EDGE_PRIME: evt = 1'b0;
            EDGE_TRACK: evt = edge_hit;
            default:    evt = 1'b0;
        endcase
    end

endmodule

// File: rtl/usbsts_port_bank.sv
module usbsts_port_bank #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] port_owner,
    input  logic [NPORTS-1:0] port_chg,
    input  logic [NPORTS-1:0] port_resume,
    input  logic [NPORTS-1:0] port_susp,
    output logic              port_evt
);

    logic [NPORTS-1:0] chg_rise;
    logic [NPORTS-1:0] res_rise;
    logic [NPORTS-1:0] hit;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        usbsts_edge_fsm #(.TOGGLE_MODE(1'b0)) u_chg (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (port_chg[p]),
            .evt   (chg_rise[p])
        );
        usbsts_edge_fsm #(.TOGGLE_MODE(1'b0)) u_res (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (port_resume[p]),
            .evt   (res_rise[p])
        );
        assign hit[p] = ~port_owner[p] & (chg_rise[p] | (res_rise[p] & port_susp[p]));
    end

    assign port_evt = |hit;

endmodule

// File: rtl/usbsts_flags.sv
module usbsts_flags
    import usbsts_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STS_BITS-1:0] set_vec,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_be0,
    input  logic [STS_BITS-1:0] wdata_lo,
    output logic [REG_W-1:0]    reg_rdata,
    output logic [STS_BITS-1:0] sts_q,
    output logic [STS_BITS-1:0] en_q,
    output logic                irq
);

    localparam logic [ADDR_W-1:0] STS_WORD = '0;
    localparam logic [ADDR_W-1:0] EN_WORD  = ADDR_W'(1);
    localparam int                PAD_W    = REG_W - STS_BITS;

    reg_sel_e            sel;
    logic [STS_BITS-1:0] clr_vec;
    logic [STS_BITS-1:0] sts_d;
    logic [STS_BITS-1:0] en_d;
    logic                lane_wr;

    always_comb begin
        sel = ACC_NONE;
        if (reg_addr == STS_WORD)     sel = ACC_STATUS;
        else if (reg_addr == EN_WORD) sel = ACC_ENABLE;
    end

    assign lane_wr = reg_wr & reg_be0;

    always_comb begin
        clr_vec = '0;
        en_d    = en_q;
        unique case (sel)
            ACC_STATUS: if (lane_wr) clr_vec = wdata_lo;
            ACC_ENABLE: if (lane_wr) en_d    = wdata_lo;
            default: ;
        endcase
        // set has priority over a same-cycle clear
        sts_d = (sts_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            en_q  <= '0;
        end else begin
            sts_q <= sts_d;
            en_q  <= en_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            ACC_STATUS: reg_rdata = {{PAD_W{1'b0}}, sts_q};
            ACC_ENABLE: reg_rdata = {{PAD_W{1'b0}}, en_q};
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |(sts_q & en_q);

endmodule

// File: rtl/usbsts_top.sv
module usbsts_top
    import usbsts_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_rollbit,
    input  logic [NPORTS-1:0] port_owner,
    input  logic [NPORTS-1:0] port_chg,
    input  logic [NPORTS-1:0] port_resume,
    input  logic [NPORTS-1:0] port_susp,
    input  logic              txn_done,
    input  logic              txn_ioc,
    input  logic              txn_err,
    input  logic              txn_short,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [3:0]        reg_be,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    logic [STS_BITS-1:0] set_vec;
    logic [STS_BITS-1:0] sts_q;
    logic [STS_BITS-1:0] en_q;
    logic                roll_evt;
    logic                port_evt;
    logic                unused_bits;

    assign unused_bits = ^{reg_be[3:1], reg_wdata[31:STS_BITS]};

    usbsts_edge_fsm #(.TOGGLE_MODE(1'b1)) u_roll (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (frame_rollbit),
        .evt   (roll_evt)
    );

    usbsts_port_bank #(.NPORTS(NPORTS)) u_ports (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_owner  (port_owner),
        .port_chg    (port_chg),
        .port_resume (port_resume),
        .port_susp   (port_susp),
        .port_evt    (port_evt)
    );

    always_comb begin
        set_vec         = '0;
        set_vec[B_TXN]  = txn_done & (txn_ioc | txn_short);
        set_vec[B_ERR]  = txn_done & txn_err;
        set_vec[B_PORT] = port_evt;
        set_vec[B_ROLL] = roll_evt;
    end

    usbsts_flags #(.ADDR_W(ADDR_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_be0   (reg_be[0]),
        .wdata_lo  (reg_wdata[STS_BITS-1:0]),
        .reg_rdata (reg_rdata),
        .sts_q     (sts_q),
        .en_q      (en_q),
        .irq       (irq)
    );

endmodule

// File: rtl/usbsts_top_chk.sv
module usbsts_top_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_rollbit,
    input logic              txn_done,
    input logic              txn_ioc,
    input logic              txn_err,
    input logic              txn_short,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [3:0]        reg_be,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [3:0]        sts_q,
    input logic [3:0]        en_q,
    input logic              irq
);

    logic armed_q;
    logic roll_prev_q;
    logic sts_wr;
    logic en_wr;

    assign sts_wr = reg_wr && (reg_addr == '0) && reg_be[0];
    assign en_wr  = reg_wr && (reg_addr == ADDR_W'(1)) && reg_be[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q     <= 1'b0;
            roll_prev_q <= 1'b0;
        end else begin
            armed_q     <= 1'b1;
            roll_prev_q <= frame_rollbit;
        end
    end

    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[31:4] == 28'd0); // R1

    AST_STICKY_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[0] && !(sts_wr && reg_wdata[0])) |=> sts_q[0]); // R2

    AST_ROLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (frame_rollbit != roll_prev_q)) |=> sts_q[3]); // R3

    AST_TXN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && (txn_ioc || txn_short)) |=> sts_q[0]); // R6

    AST_ERR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && txn_err && txn_ioc) |=> (sts_q[0] && sts_q[1])); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && txn_err && sts_wr && reg_wdata[1]) |=> sts_q[1]); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == 4'd0) |-> !irq); // R9

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q)); // R9

endmodule

bind usbsts_top usbsts_top_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_rollbit (frame_rollbit),
    .txn_done      (txn_done),
    .txn_ioc       (txn_ioc),
    .txn_err       (txn_err),
    .txn_short     (txn_short),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_be        (reg_be),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .sts_q         (sts_q),
    .en_q          (en_q),
    .irq           (irq)
);

// File: tb/usbsts_top_tb_top.sv
`timescale 1ns/1ps
module usbsts_top_tb_top;

    localparam int NP = 2;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_rollbit = 1'b0;
    logic [NP-1:0] port_owner = '0;
    logic [NP-1:0] port_chg = '0;
    logic [NP-1:0] port_resume = '0;
    logic [NP-1:0] port_susp = '0;
    logic          txn_done = 1'b0;
    logic          txn_ioc = 1'b0;
    logic          txn_err = 1'b0;
    logic          txn_short = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [3:0]    reg_be = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    usbsts_top #(.NPORTS(NP), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_rollbit(frame_rollbit),
        .port_owner(port_owner), .port_chg(port_chg),
        .port_resume(port_resume), .port_susp(port_susp),
        .txn_done(txn_done), .txn_ioc(txn_ioc), .txn_err(txn_err),
        .txn_short(txn_short), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0; reg_addr = '0;
    endtask

    task automatic set_status(input logic [3:0] s);
        wr(0, 4'h1, 32'hF);
        @(negedge clk);
        txn_done = 1'b1; txn_ioc = s[0]; txn_err = s[1];
        port_chg[0] = s[2];
        frame_rollbit = frame_rollbit ^ s[3];
        @(negedge clk);
        txn_done = 1'b0; txn_ioc = 1'b0; txn_err = 1'b0; port_chg = '0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        do_reset();
        // R1: reset state
        rd(0, d); chk("R1 status after reset", d, 32'h0);
        rd(1, d); chk("R1 enable after reset", d, 32'h0);
        chk("R1 irq after reset", {31'd0, irq}, 32'h0);

        // R3: first cycle after reset only samples
        frame_rollbit = 1'b1;
        do_reset();
        repeat (3) @(negedge clk);
        rd(0, d); chk("R3 no rollover from reset sample", d, 32'h0);
        frame_rollbit = 1'b0;
        @(negedge clk);
        rd(0, d); chk("R3 falling toggle sets", d, 32'h8);
        wr(0, 4'h1, 32'h8);
        repeat (3) @(negedge clk);
        rd(0, d); chk("R3 steady bit no set", d, 32'h0);
        frame_rollbit = 1'b1;
        @(negedge clk);
        rd(0, d); chk("R3 rising toggle sets", d, 32'h8);
        wr(0, 4'h1, 32'h8);

        // R1: upper bits and other words
        wr(1, 4'hF, 32'hFFFF_FFFF);
        rd(1, d); chk("R1 enable upper bits zero", d, 32'hF);
        wr(2, 4'hF, 32'hFFFF_FFFF);
        rd(2, d); chk("R1 unmapped word reads zero", d, 32'h0);
        rd(1, d); chk("R1 unmapped write no effect", d, 32'hF);
        wr(1, 4'hE, 32'h0);
        rd(1, d); chk("R9 enable ignores be0=0", d, 32'hF);
        wr(1, 4'h1, 32'h0);

        // R2: write-one-clear over all patterns
        for (int c = 0; c < 16; c++) begin
            set_status(4'hF);
            rd(0, d); chk("R2 all flags set", d, 32'hF);
            wr(0, 4'hE, 32'(c));
            rd(0, d); chk("R2 be0=0 no clear", d, 32'hF);
            wr(0, 4'hF, 32'(c) << 8);
            rd(0, d); chk("R2 other lane no clear", d, 32'hF);
            wr(0, 4'h1, 32'(c));
            rd(0, d); chk("R2 clear pattern", d, 32'(4'hF & ~4'(c)));
        end

        // R6/R7: transaction completion sweep
        for (int v = 0; v < 16; v++) begin
            logic [3:0] b;
            logic [31:0] e;
            b = 4'(v);
            wr(0, 4'h1, 32'hF);
            @(negedge clk);
            txn_done = b[0]; txn_ioc = b[1]; txn_err = b[2]; txn_short = b[3];
            @(negedge clk);
            txn_done = 1'b0; txn_ioc = 1'b0; txn_err = 1'b0; txn_short = 1'b0;
            e = {30'd0, b[0] & b[2], b[0] & (b[1] | b[3])};
            rd(0, d);
            if (b[0] && b[1] && b[2]) chk("R7 error with ioc sets both", d, e);
            else                      chk("R6 R7 completion flags", d, e);
        end

        // R4/R5: port sweep
        for (int p = 0; p < NP; p++) begin
            for (int own = 0; own < 2; own++) begin
                for (int kind = 0; kind < 2; kind++) begin
                    for (int sp = 0; sp < 2; sp++) begin
                        logic exp_set;
                        wr(0, 4'h1, 32'hF);
                        port_owner[p] = own[0];
                        port_susp[p] = sp[0];
                        @(negedge clk);
                        if (kind == 1) port_resume[p] = 1'b1;
                        else           port_chg[p] = 1'b1;
                        @(negedge clk);
                        exp_set = (own == 0) && (kind == 0 || sp == 1);
                        rd(0, d);
                        if (kind == 0) chk("R4 change rise", d, exp_set ? 32'h4 : 32'h0);
                        else           chk("R5 resume rise", d, exp_set ? 32'h4 : 32'h0);
                        port_chg = '0; port_resume = '0;
                        @(negedge clk);
                        port_owner = '0; port_susp = '0;
                    end
                end
            end
        end
        // R4: held change bit does not re-set after clear
        wr(0, 4'h1, 32'hF);
        port_chg[1] = 1'b1;
        @(negedge clk);
        wr(0, 4'h1, 32'h4);
        repeat (2) @(negedge clk);
        rd(0, d); chk("R4 held change no re-set", d, 32'h0);
        port_chg = '0;
        @(negedge clk);

        // R8: set beats same-cycle clear
        set_status(4'hF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = '0; reg_be = 4'h1; reg_wdata = 32'hF;
        txn_done = 1'b1; txn_err = 1'b1;
        frame_rollbit = ~frame_rollbit;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
        txn_done = 1'b0; txn_err = 1'b0;
        rd(0, d); chk("R8 set wins over clear", d, 32'hA);

        // R9: irq over all status and enable pairs
        for (int s = 0; s < 16; s++) begin
            wr(1, 4'h1, 32'h0);
            set_status(4'(s));
            rd(0, d); chk("R9 status preset", d, 32'(s));
            for (int e = 0; e < 16; e++) begin
                wr(1, 4'h1, 32'(e));
                rd(1, d); chk("R9 enable readback", d, 32'(e));
                chk("R9 irq", {31'd0, irq}, {31'd0, |(4'(s) & 4'(e))});
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule